// File: doc/BRIEF.md
# Strobed Parallel Host Slave Port

This block lets an external host controller trade bytes with an embedded processor over an 8-bit bidirectional bus. The host owns two pins: an active-low strobe and a direction select, where high means the host reads and low means it writes. The block owns two active-low ready flags, one per direction, and tells the host through them when a transfer may begin. Everything on the core side is synchronous to one system clock. The host pins pass through a synchronizer, and the strobe's rising edge is found in the clock domain.

The core arms a direction by pulsing a port bit low-high-low; the flag drops on the falling edge of that pulse. For input, the host then strobes a byte in. The block latches it, raises the input flag and pulses the write interrupt, and the core reads the byte from the receive register. For output, the core first loads the transmit register and then arms. The block drives that byte while the host holds the strobe low in read direction. On the strobe's rise it releases the bus, raises the output flag and pulses the read interrupt. A mode bit that resets to slave mode turns the whole interface off when set to master.

Top module: `host_slave_port`

## Requirements
- R1: After reset both ready flags are high, both interrupts are low, the bus enable is low, the mode reads 0 (slave) and the receive register holds 0.
- R2: A falling edge on `arm_in_bit` (1 in one cycle, 0 in the next) drives `in_rdy_n` low at the next clock edge. Holding the bit at 1 leaves the flag high.
- R3: A strobe rising edge with `host_rw` = 0 while `in_rdy_n` is low latches the bus byte into `rx_data`, and `in_rdy_n` is high again within three clock edges of that rise.
- R4: `irq_host_wr` is a one-cycle pulse in the same cycle that `in_rdy_n` returns high, and `rx_data` already holds the new byte in that cycle.
- R5: A falling edge on `arm_out_bit` drives `out_rdy_n` low at the next clock edge without touching `in_rdy_n`.
- R6: `host_data_oe` is high exactly while in slave mode with `out_rdy_n` low, `host_rw` = 1 and `host_strobe_n` = 0. `host_data_o` then carries the last byte written through `tx_we`. The enable drops as soon as the strobe rises.
- R7: A strobe rising edge with `host_rw` = 1 while `out_rdy_n` is low returns `out_rdy_n` high within three clock edges, with a one-cycle `irq_host_rd` pulse in that cycle.
- R8: A strobe rising edge in a direction whose flag is high is ignored: no latch, no flag change, no interrupt and no bus drive.
- R9: Writing 1 to the mode bit selects master mode. In master mode both flags are forced high, arm pulses and strobes are ignored and the bus is never driven. Writing 0 restores slave mode.
- R10: A mode write never raises an interrupt, even when it drops an armed flag. Rewriting slave mode leaves an armed flag armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_strobe_n | input | 1 | Host transfer strobe, active low |
| host_rw | input | 1 | Host direction: 1 read, 0 write |
| host_data_i | input | DATA_W | Bus value seen at the pads |
| host_data_o | output | DATA_W | Byte driven towards the host |
| host_data_oe | output | 1 | Pad output enable for the bus |
| in_rdy_n | output | 1 | Ready-to-receive flag, active low |
| out_rdy_n | output | 1 | Ready-to-send flag, active low |
| mode_we | input | 1 | Mode bit write strobe |
| mode_wdata | input | 1 | Mode value: 1 master, 0 slave |
| mode_master | output | 1 | Current mode bit |
| tx_we | input | 1 | Load strobe for the transmit byte |
| tx_data | input | DATA_W | Transmit byte from the core |
| arm_in_bit | input | 1 | Port bit whose falling edge arms the input direction |
| arm_out_bit | input | 1 | Port bit whose falling edge arms the output direction |
| rx_data | output | DATA_W | Last byte latched from the host |
| irq_host_wr | output | 1 | One-cycle pulse when a host write completes |
| irq_host_rd | output | 1 | One-cycle pulse when a host read completes |

## Verification
The bench builds the block with its defaults: an 8-bit bus and a two-stage synchronizer. With these values the flag's return falls on the third clock edge after the strobe rises, so the three-edge bound is checked at its limit. The scoreboard then matches every interrupt pulse against a byte the host driver expected to move. Wrong-direction strobes, strobes on unarmed flags and mode writes that drop an armed flag all sit within a few cycles of one another. Any interrupt the design raises in those cases finds an empty queue and is reported.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic {
    DIR_HOST_WRITE = 1'b0,
    DIR_HOST_READ  = 1'b1
  } hsp_dir_e;

  localparam int unsigned NUM_DIRS = 2;
  localparam int unsigned IDX_IN   = 0;
  localparam int unsigned IDX_OUT  = 1;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int unsigned      WIDTH     = 1,
  parameter int unsigned      STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RESET_VAL;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hsp_channel.sv
module hsp_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic arm_bit_i,
  input  logic release_i,
  output logic rdy_n_o,
  output logic irq_o
);
  logic arm_prev_q, arm_prev_d;
  logic armed_q, armed_d;
  logic irq_q, irq_d;
  logic arm_fall, release_hit;

  always_comb begin
    arm_fall    = arm_prev_q & ~arm_bit_i;
    release_hit = enable_i & armed_q & release_i;
    arm_prev_d  = arm_bit_i;
    irq_d       = release_hit;
    if (!enable_i)        armed_d = 1'b0;
    else if (release_hit) armed_d = 1'b0;
    else if (arm_fall)    armed_d = 1'b1;
    else                  armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_prev_q <= 1'b0;
      armed_q    <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      arm_prev_q <= arm_prev_d;
      armed_q    <= armed_d;
      irq_q      <= irq_d;
    end
  end

  assign rdy_n_o = ~armed_q;
  assign irq_o   = irq_q;

  // The interrupt appears in exactly the cycle the flag returned high.
  assert_irq_with_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (rdy_n_o && !$past(rdy_n_o)));

  // One-cycle interrupt pulse.
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // A flag only drops after a falling edge of the arm bit in slave mode.
  assert_arm_from_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n_o) |-> $past(arm_prev_q && !arm_bit_i && enable_i));

  // Disabled interface leaves the flag high and quiet.
  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (rdy_n_o && !irq_q));
endmodule

// File: rtl/host_slave_port.sv
module host_slave_port
  import hsp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe_n,
  input  logic              host_rw,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe,
  output logic              in_rdy_n,
  output logic              out_rdy_n,
  input  logic              mode_we,
  input  logic              mode_wdata,
  output logic              mode_master,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              arm_in_bit,
  input  logic              arm_out_bit,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq_host_wr,
  output logic              irq_host_rd
);
  localparam int unsigned CTL_W = 2;

  logic [CTL_W-1:0]    ctl_s;
  logic [DATA_W-1:0]   bus_s;
  logic                rw_s, strobe_s;
  logic                strobe_prev_q, strobe_prev_d;
  logic                strobe_rise;
  logic                mode_q, mode_d;
  logic                slave_en;
  logic [DATA_W-1:0]   rx_q, rx_d;
  logic [DATA_W-1:0]   tx_q, tx_d;
  logic                rx_capture;
  logic [NUM_DIRS-1:0] arm_vec, release_vec, rdy_n_vec, irq_vec;

  hsp_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RESET_VAL(2'b01)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({host_rw, host_strobe_n}), .q(ctl_s));

  hsp_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(host_data_i), .q(bus_s));

  assign rw_s     = ctl_s[1];
  assign strobe_s = ctl_s[0];

  always_comb begin
    strobe_prev_d = strobe_s;
    strobe_rise   = strobe_s & ~strobe_prev_q;
    mode_d        = mode_we ? mode_wdata : mode_q;
    slave_en      = ~mode_d;
    release_vec[IDX_IN]  = strobe_rise & (rw_s == DIR_HOST_WRITE);
    release_vec[IDX_OUT] = strobe_rise & (rw_s == DIR_HOST_READ);
    rx_capture    = release_vec[IDX_IN] & slave_en & ~rdy_n_vec[IDX_IN];
    rx_d          = rx_capture ? bus_s : rx_q;
    tx_d          = tx_we ? tx_data : tx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev_q <= 1'b1;
      mode_q        <= 1'b0;
      rx_q          <= '0;
      tx_q          <= '0;
    end else begin
      strobe_prev_q <= strobe_prev_d;
      mode_q        <= mode_d;
      rx_q          <= rx_d;
      tx_q          <= tx_d;
    end
  end

  assign arm_vec[IDX_IN]  = arm_in_bit;
  assign arm_vec[IDX_OUT] = arm_out_bit;

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
    hsp_channel u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (slave_en),
      .arm_bit_i (arm_vec[g]),
      .release_i (release_vec[g]),
      .rdy_n_o   (rdy_n_vec[g]),
      .irq_o     (irq_vec[g])
    );
  end

  assign in_rdy_n     = rdy_n_vec[IDX_IN];
  assign out_rdy_n    = rdy_n_vec[IDX_OUT];
  assign irq_host_wr  = irq_vec[IDX_IN];
  assign irq_host_rd  = irq_vec[IDX_OUT];
  assign mode_master  = mode_q;
  assign rx_data      = rx_q;
  assign host_data_o  = tx_q;
  assign host_data_oe = ~mode_q & ~rdy_n_vec[IDX_OUT] & host_rw & ~host_strobe_n;

  // No interface interrupt while the mode bit holds master.
  assert_no_irq_in_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !(irq_host_wr || irq_host_rd));

  // The receive byte only changes together with a completed host write.
  assert_rx_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_q) |-> irq_host_wr);

  // The host sees the transmit byte only while the output flag is armed.
  assert_drive_needs_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_oe |-> (!out_rdy_n && !mode_master));
endmodule

// File: tb/host_slave_port_bench.sv
module host_slave_port_bench;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_strobe_n, host_rw;
  logic [DW-1:0] host_data_i, host_data_o, tx_data, rx_data;
  logic          host_data_oe, in_rdy_n, out_rdy_n;
  logic          mode_we, mode_wdata, mode_master, tx_we;
  logic          arm_in_bit, arm_out_bit, irq_host_wr, irq_host_rd;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  bit  running = 1'b0;
  logic [DW-1:0] wr_q[$];
  logic [DW-1:0] rd_q[$];
  logic [DW-1:0] host_seen;
  logic          oe_during, oe_after, rdy_after;
  logic          prev_wr = 1'b0, prev_rd = 1'b0;

  always #4 clk = ~clk;

  host_slave_port u_host_slave_port (
    .clk(clk), .rst_n(rst_n), .host_strobe_n(host_strobe_n), .host_rw(host_rw),
    .host_data_i(host_data_i), .host_data_o(host_data_o), .host_data_oe(host_data_oe),
    .in_rdy_n(in_rdy_n), .out_rdy_n(out_rdy_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_master(mode_master), .tx_we(tx_we), .tx_data(tx_data), .arm_in_bit(arm_in_bit),
    .arm_out_bit(arm_out_bit), .rx_data(rx_data), .irq_host_wr(irq_host_wr),
    .irq_host_rd(irq_host_rd));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every interrupt pulse must match an item the driver queued.
  always @(negedge clk) begin
    if (running) begin
      if (irq_host_wr) begin
        if (wr_q.size() == 0) check(1'b0, "R8 or R10 unexpected write irq", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = wr_q.pop_front();
          check(rx_data == e, "R4 rx byte at irq", rx_data, e);
        end
        if (prev_wr) check(1'b0, "R4 write irq longer than one cycle", 2, 1);
      end
      if (irq_host_rd) begin
        if (rd_q.size() == 0) check(1'b0, "R8 or R10 unexpected read irq", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = rd_q.pop_front();
          check(host_seen == e, "R7 byte seen by host", host_seen, e);
        end
        if (prev_rd) check(1'b0, "R7 read irq longer than one cycle", 2, 1);
      end
      prev_wr = irq_host_wr;
      prev_rd = irq_host_rd;
    end
  end

  task automatic arm(input bit out_dir);
    @(negedge clk);
    if (out_dir) arm_out_bit = 1'b1; else arm_in_bit = 1'b1;
    @(negedge clk);
    check((out_dir ? out_rdy_n : in_rdy_n) == 1'b1, "R2 level high does not arm",
          out_dir ? out_rdy_n : in_rdy_n, 1);
    if (out_dir) arm_out_bit = 1'b0; else arm_in_bit = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [DW-1:0] b, input bit accepted);
    @(negedge clk);
    host_rw = 1'b0; host_data_i = b; host_strobe_n = 1'b0;
    repeat (2) @(negedge clk);
    if (accepted) wr_q.push_back(b);
    host_strobe_n = 1'b1;
    repeat (3) @(negedge clk);
    rdy_after = in_rdy_n;
    @(negedge clk);
    host_data_i = '0;
  endtask

  task automatic host_read();
    @(negedge clk);
    host_rw = 1'b1; host_strobe_n = 1'b0;
    repeat (2) @(negedge clk);
    oe_during = host_data_oe;
    host_seen = host_data_o;
    host_strobe_n = 1'b1;
    #1 oe_after = host_data_oe;
    repeat (3) @(negedge clk);
    rdy_after = out_rdy_n;
    @(negedge clk);
    host_rw = 1'b0;
  endtask

  task automatic load_tx(input logic [DW-1:0] b);
    @(negedge clk); tx_we = 1'b1; tx_data = b;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic write_mode(input bit v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; host_strobe_n = 1'b1; host_rw = 1'b0; host_data_i = '0;
    mode_we = 1'b0; mode_wdata = 1'b0; tx_we = 1'b0; tx_data = '0;
    arm_in_bit = 1'b0; arm_out_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1'b1;
    check(in_rdy_n == 1'b1, "R1 in_rdy_n after reset", in_rdy_n, 1);
    check(out_rdy_n == 1'b1, "R1 out_rdy_n after reset", out_rdy_n, 1);
    check(!irq_host_wr && !irq_host_rd, "R1 irqs after reset", {irq_host_wr, irq_host_rd}, 0);
    check(host_data_oe == 1'b0, "R1 bus enable after reset", host_data_oe, 0);
    check(mode_master == 1'b0, "R1 slave mode after reset", mode_master, 0);
    check(rx_data == '0, "R1 rx_data after reset", rx_data, 0);

    // Host write path
    arm(1'b0);
    check(in_rdy_n == 1'b0, "R2 in_rdy_n low after arm pulse", in_rdy_n, 0);
    host_write(8'hA5, 1'b1);
    check(rdy_after == 1'b1, "R3 in_rdy_n high within three edges", rdy_after, 1);
    check(rx_data == 8'hA5, "R3 latched byte", rx_data, 8'hA5);
    arm(1'b0);
    host_write(8'h3C, 1'b1);
    check(rx_data == 8'h3C, "R3 second latched byte", rx_data, 8'h3C);

    // Write strobe while flag high: ignored
    host_write(8'h77, 1'b0);
    check(rx_data == 8'h3C, "R8 unarmed write not latched", rx_data, 8'h3C);
    check(in_rdy_n == 1'b1, "R8 unarmed write flag unchanged", in_rdy_n, 1);

    // Host read path
    load_tx(8'h96);
    arm(1'b1);
    check(out_rdy_n == 1'b0, "R5 out_rdy_n low after arm pulse", out_rdy_n, 0);
    check(in_rdy_n == 1'b1, "R5 in_rdy_n untouched", in_rdy_n, 1);
    rd_q.push_back(8'h96);
    host_read();
    check(oe_during == 1'b1, "R6 bus driven during read strobe", oe_during, 1);
    check(host_seen == 8'h96, "R6 bus carries tx byte", host_seen, 8'h96);
    check(oe_after == 1'b0, "R6 bus released after strobe rise", oe_after, 0);
    check(rdy_after == 1'b1, "R7 out_rdy_n high within three edges", rdy_after, 1);

    // Read strobe while output flag high
    host_read();
    check(oe_during == 1'b0, "R8 unarmed read not driven", oe_during, 0);
    check(rdy_after == 1'b1, "R8 unarmed read flag unchanged", rdy_after, 1);

    // Wrong direction: input armed, host reads
    arm(1'b0);
    host_read();
    check(in_rdy_n == 1'b0, "R8 read strobe leaves input armed", in_rdy_n, 0);
    check(oe_during == 1'b0, "R8 read strobe with output idle", oe_during, 0);
    host_write(8'h5A, 1'b1);
    check(rx_data == 8'h5A, "R3 write after wrong-direction strobe", rx_data, 8'h5A);

    // Master mode
    arm(1'b0);
    write_mode(1'b1);
    check(mode_master == 1'b1, "R9 master mode selected", mode_master, 1);
    check(in_rdy_n == 1'b1, "R10 master write drops flag", in_rdy_n, 1);
    arm(1'b0);
    check(in_rdy_n == 1'b1, "R9 arm ignored in master", in_rdy_n, 1);
    arm(1'b1);
    host_read();
    check(oe_during == 1'b0, "R9 bus not driven in master", oe_during, 0);
    host_write(8'hE1, 1'b0);
    check(rx_data == 8'h5A, "R9 write ignored in master", rx_data, 8'h5A);
    write_mode(1'b0);
    check(mode_master == 1'b0, "R9 slave mode restored", mode_master, 0);
    arm(1'b0);
    check(in_rdy_n == 1'b0, "R9 arming works again", in_rdy_n, 0);
    host_write(8'hC3, 1'b1);
    check(rx_data == 8'hC3, "R9 write after return to slave", rx_data, 8'hC3);

    // Rewriting slave mode keeps an armed flag
    load_tx(8'h4B);
    arm(1'b1);
    write_mode(1'b0);
    check(out_rdy_n == 1'b0, "R10 slave rewrite keeps flag", out_rdy_n, 0);
    rd_q.push_back(8'h4B);
    host_read();
    check(host_seen == 8'h4B, "R6 second tx byte", host_seen, 8'h4B);

    repeat (10) @(negedge clk);
    check(wr_q.size() == 0, "R4 every write raised its irq", wr_q.size(), 0);
    check(rd_q.size() == 0, "R7 every read raised its irq", rd_q.size(), 0);
    running = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule